// File: doc/BRIEF.md
# Predicated-Core Arithmetic Unit with Condition Flags

This block is the arithmetic unit of a small predicated RISC core. An operation is offered on `start` together with a 5-bit operation code and two signed 32-bit operands. One `done` pulse later, the block presents a 32-bit result and a 4-bit one-hot condition code. The surrounding core stores that code and uses it to predicate later instructions. The block performs:

- wrapping add, subtract and multiply;
- floor division;
- the base-plus-offset address sum used by loads and stores.

A zero divisor is not treated as a fault. It is reported through the error flag of the condition code.

A three-state controller sequences the work:

- **IDLE** waits for `start`.
  - A division by a nonzero divisor takes transition *IDLE→DIVIDE*.
  - Every other operation takes *IDLE→REPLY*.
- **DIVIDE** runs a restoring divider for one quotient bit per clock and raises `busy`. It stays in DIVIDE (*DIVIDE→DIVIDE*) until the last bit, then takes *DIVIDE→REPLY*.
- **REPLY** asserts `done` for exactly one cycle and always returns through *REPLY→IDLE*.

The result and condition registers keep their values until the next operation completes.

Top module: `cond_alu`

## Requirements
- R1: Operation code 3 returns a+b and code 5 returns a−b, both wrapped modulo 2^32 with no overflow detection.
- R2: Operation code 6 returns the low 32 bits of the signed product a×b.
- R3: Operation code 7 with b≠0 returns the quotient rounded toward negative infinity (12/−3=−4, −7/2=−4, 3/4=0), wrapped to 32 bits.
- R4: Operation code 7 with b=0 returns result 0 and condition 4'b1000 (V).
- R5: Operation codes 1 and 2 return the address sum a+b.
- R6: Operation code 0 returns 0 with condition 4'b0010 (Z). Codes 4 and 8–31 return 0 with condition 4'b1000 (V).
- R7: For every result that is not an error, the condition is one-hot from the result: bit 0 (M) when negative, bit 1 (Z) when zero, bit 2 (P) when positive.
- R8: `done` is a single-cycle pulse. For all operations except a division by a nonzero divisor, it is high in the cycle after the accepting edge. For a division by a nonzero divisor, it is high 33 cycles after the accepting edge, with `busy` high and `done` low in between.
- R9: `start` is ignored while `busy` or `done` is high. Such a request does not alter the result, the condition or the timing of the operation in flight.
- R10: After reset, `busy`, `done`, `result` and `cond` are 0. `result` and `cond` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only in IDLE |
| op | input | 5 | Operation code |
| a | input | 32 | Left operand, signed |
| b | input | 32 | Right operand, signed |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result of the last completed operation |
| cond | output | 4 | Condition code {V,P,Z,M} of the last completed operation |

## Verification
Directed cases cover several boundaries:
- sign and zero boundaries of each operation;
- add and multiply wrap-around;
- the four sign pairings of a division with and without remainder;
- the most negative dividend over −1;
- HALT and unused codes.

Together these separate correct flooring from truncation and tell M from Z from P. Seeded random operations then mix small and full-range operands, including frequent zero divisors, so that every code path is checked against a bench model. That model is built on 64-bit arithmetic. Dedicated sequences issue `start` during DIVIDE and during REPLY to show that such requests are dropped. Idle gaps show that the result is held.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
    localparam int OP_W = 5;
    localparam int CC_W = 4;

    localparam logic [OP_W-1:0] OP_HALT  = 5'd0;
    localparam logic [OP_W-1:0] OP_LOAD  = 5'd1;
    localparam logic [OP_W-1:0] OP_STORE = 5'd2;
    localparam logic [OP_W-1:0] OP_ADD   = 5'd3;
    localparam logic [OP_W-1:0] OP_SUB   = 5'd5;
    localparam logic [OP_W-1:0] OP_MUL   = 5'd6;
    localparam logic [OP_W-1:0] OP_DIV   = 5'd7;

    localparam logic [CC_W-1:0] CC_M = 4'b0001;
    localparam logic [CC_W-1:0] CC_Z = 4'b0010;
    localparam logic [CC_W-1:0] CC_P = 4'b0100;
    localparam logic [CC_W-1:0] CC_V = 4'b1000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_REPLY
    } state_e;
endpackage

// File: rtl/cond_alu_flags.sv
module cond_alu_flags
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    value,
    output logic [CC_W-1:0] flags
);
    always_comb begin
        if (value == '0)
            flags = CC_Z;
        else if (value[W-1])
            flags = CC_M;
        else
            flags = CC_P;
    end
endmodule

// File: rtl/cond_alu_divider.sv
module cond_alu_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot_floor
);
    logic [W-1:0] rem_q, acc_q, dvs_q;
    logic         neg_q;
    logic [W:0]   shifted, trial;
    logic         fits;
    logic [W-1:0] rem_n, acc_n, q_signed;

    always_comb begin
        shifted  = {rem_q, acc_q[W-1]};
        trial    = shifted - {1'b0, dvs_q};
        fits     = ~trial[W];
        rem_n    = fits ? trial[W-1:0] : shifted[W-1:0];
        acc_n    = {acc_q[W-2:0], fits};
        q_signed = neg_q ? (~acc_n + 1'b1) : acc_n;
        quot_floor = (neg_q && rem_n != '0) ? q_signed - 1'b1 : q_signed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            acc_q <= '0;
            dvs_q <= '0;
            neg_q <= 1'b0;
        end else if (load) begin
            rem_q <= '0;
            acc_q <= dividend[W-1] ? (~dividend + 1'b1) : dividend;
            dvs_q <= divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
            neg_q <= dividend[W-1] ^ divisor[W-1];
        end else if (step) begin
            rem_q <= rem_n;
            acc_q <= acc_n;
        end
    end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    result,
    output logic [CC_W-1:0] cond
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept, go_div, last_step, load_out;
    logic [W-1:0]     quick_res, quot_floor, res_sel;
    logic             quick_err;
    logic [CC_W-1:0]  flags;
    logic [W-1:0]     prod;

    assign accept    = start && (state_q == ST_IDLE);
    assign go_div    = (op == OP_DIV) && (b != '0);
    assign last_step = (state_q == ST_DIVIDE) && (cnt_q == LAST_BIT);
    assign prod      = a * b;

    // single-cycle operations
    always_comb begin
        quick_err = 1'b0;
        unique case (op)
            OP_ADD, OP_LOAD, OP_STORE: quick_res = a + b;
            OP_SUB:                    quick_res = a - b;
            OP_MUL:                    quick_res = prod;
            OP_HALT:                   quick_res = '0;
            default: begin
                quick_res = '0;
                quick_err = 1'b1;
            end
        endcase
    end

    assign res_sel = (state_q == ST_DIVIDE) ? quot_floor : quick_res;

    cond_alu_flags #(.W(W)) u_flags (
        .value (res_sel),
        .flags (flags)
    );

    cond_alu_divider #(.W(W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept && go_div),
        .step       (state_q == ST_DIVIDE),
        .dividend   (a),
        .divisor    (b),
        .quot_floor (quot_floor)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = go_div ? ST_DIVIDE : ST_REPLY;
            ST_DIVIDE: if (last_step) state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                cnt_q <= '0;
            else if (state_q == ST_DIVIDE)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    assign load_out = (accept && !go_div) || last_step;
    assign busy     = (state_q == ST_DIVIDE);
    assign done     = (state_q == ST_REPLY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            cond   <= '0;
        end else if (load_out) begin
            if (state_q == ST_IDLE && quick_err) begin
                result <= '0;
                cond   <= CC_V;
            end else begin
                result <= res_sel;
                cond   <= flags;
            end
        end
    end
endmodule

// File: rtl/cond_alu_chk.sv
module cond_alu_chk
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [OP_W-1:0] op,
    input logic            busy,
    input logic            done,
    input logic [W-1:0]    result,
    input logic [CC_W-1:0] cond
);
    logic [OP_W-1:0] acc_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_op <= '0;
        else if (start && !busy && !done)
            acc_op <= op;
    end

    AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones(cond) == 1);                                    // R7
    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cond[3]) |-> (cond[0] == result[W-1]));                   // R7
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cond[3]) |-> result == '0);                                // R4
    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && acc_op == OP_HALT) |-> (result == '0 && cond == CC_Z));    // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R8
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);                                                    // R8
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !busy) |-> ($stable(result) && $stable(cond)));           // R10
endmodule

bind cond_alu cond_alu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .busy   (busy),
    .done   (done),
    .result (result),
    .cond   (cond)
);

// File: tb/sim_cond_alu.sv
module sim_cond_alu;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int DIV_LAT = DW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    op = '0;
    logic [DW-1:0] a = '0, b = '0;
    logic          busy, done;
    logic [DW-1:0] result;
    logic [3:0]    cond;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_alu #(.W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .busy(busy), .done(done), .result(result), .cond(cond)
    );

    function automatic logic [3:0] sign_cc(input logic [DW-1:0] r);
        if (r == '0) return 4'b0010;
        if (r[DW-1]) return 4'b0001;
        return 4'b0100;
    endfunction

    task automatic model(input logic [4:0] o, input logic [DW-1:0] x, input logic [DW-1:0] y,
                         output logic [DW-1:0] r, output logic [3:0] c, output int lat);
        longint sx, sy, q;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        lat = 1;
        c = 4'b0000;
        case (o)
            5'd3, 5'd1, 5'd2: r = x + y;
            5'd5: r = x - y;
            5'd6: begin q = sx * sy; r = q[DW-1:0]; end
            5'd0: r = '0;
            5'd7: begin
                if (y == '0) begin
                    r = '0; c = 4'b1000;
                end else begin
                    q = sx / sy;
                    if ((sx % sy) != 0 && ((sx < 0) != (sy < 0))) q = q - 1;
                    r = q[DW-1:0];
                    lat = DIV_LAT;
                end
            end
            default: begin r = '0; c = 4'b1000; end
        endcase
        if (c == 4'b0000) c = sign_cc(r);
    endtask

    task automatic check(input string tag, input logic ok, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // issue one op, measure latency, compare outputs
    task automatic run_op(input string tag, input logic [4:0] o,
                          input logic [DW-1:0] x, input logic [DW-1:0] y);
        logic [DW-1:0] er; logic [3:0] ec; int el; int lat;
        model(o, x, y, er, ec, el);
        start = 1'b1; op = o; a = x; b = y;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
        check(tag, (result == er) && (cond == ec) && (lat == el),
              $sformatf("op=%0d a=%0h b=%0h res/cond/lat", o, x, y),
              {result, cond, 8'(lat)}, {er, ec, 8'(el)});
        @(posedge clk); @(negedge clk);
        check("R8", !done, "done after pulse", longint'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] hold_r; logic [3:0] hold_c; int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10", busy == 0 && done == 0 && result == 0 && cond == 0,
              "reset outputs", {busy, done, result, cond}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_op("R1", 5'd3, 32'd5, 32'd3);
        run_op("R1", 5'd3, -32'sd5, 32'd3);
        run_op("R1", 5'd3, -32'sd10, 32'd10);
        run_op("R1", 5'd3, 32'h7fffffff, 32'd1);
        run_op("R1", 5'd5, 32'd3, 32'd5);
        run_op("R1", 5'd5, 32'd3, 32'd3);
        run_op("R2", 5'd6, -32'sd3, 32'd5);
        run_op("R2", 5'd6, 32'd0, 32'd22);
        run_op("R2", 5'd6, 32'h10000, 32'h10000);
        run_op("R3", 5'd7, 32'd12, -32'sd3);
        run_op("R3", 5'd7, 32'd3, 32'd4);
        run_op("R3", 5'd7, -32'sd7, 32'd2);
        run_op("R3", 5'd7, 32'd7, -32'sd2);
        run_op("R3", 5'd7, -32'sd7, -32'sd2);
        run_op("R3", 5'd7, 32'h80000000, 32'hffffffff);
        run_op("R3", 5'd7, 32'h80000000, 32'd1);
        run_op("R4", 5'd7, 32'd12, 32'd0);
        run_op("R5", 5'd1, 32'd12, 32'd13);
        run_op("R5", 5'd2, 32'd27, -32'sd40);
        run_op("R6", 5'd0, 32'd99, 32'd98);
        run_op("R6", 5'd4, 32'd1, 32'd2);
        run_op("R6", 5'd31, 32'd1, 32'd2);
        run_op("R7", 5'd5, 32'd0, 32'd1);

        // R10: outputs hold while idle
        hold_r = result; hold_c = cond;
        a = 32'd77; b = 32'd1; op = 5'd3;
        repeat (4) @(negedge clk);
        check("R10", result == hold_r && cond == hold_c, "hold while idle",
              {result, cond}, {hold_r, hold_c});

        // R9: start during DIVIDE is dropped
        start = 1'b1; op = 5'd7; a = 32'd100; b = 32'd7;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (4) begin @(posedge clk); @(negedge clk); lat++; end
        start = 1'b1; op = 5'd3; a = 32'd1; b = 32'd1;
        @(posedge clk); @(negedge clk);
        start = 1'b0; lat++;
        while (!done && lat < 200) begin @(posedge clk); @(negedge clk); lat++; end
        check("R9", result == 32'd14 && cond == 4'b0100 && lat == DIV_LAT,
              "start while busy", {result, cond, 8'(lat)}, {32'd14, 4'b0100, 8'(DIV_LAT)});
        // R9: start during REPLY is dropped
        start = 1'b1; op = 5'd3; a = 32'd5; b = 32'd5;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", !done && !busy && result == 32'd14, "start while done",
              {busy, done, result}, {2'b00, 32'd14});

        // seeded random mix
        for (int i = 0; i < 300; i++) begin
            logic [4:0] ro; logic [DW-1:0] ra, rb; int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: ro = 5'd0; 1: ro = 5'd1; 2: ro = 5'd2; 3: ro = 5'd3;
                4: ro = 5'd5; 5: ro = 5'd6; 6, 7: ro = 5'd7;
                8: ro = 5'd4;
                default: ro = 5'($urandom_range(8, 31));
            endcase
            if ($urandom_range(0, 1) == 0) begin
                ra = $urandom; rb = $urandom;
            end else begin
                ra = DW'($signed(9'($urandom_range(0, 511))));
                rb = DW'($signed(5'($urandom_range(0, 31))));
            end
            if ($urandom_range(0, 7) == 0) rb = '0;
            run_op(ro == 5'd7 ? (rb == 0 ? "R4" : "R3") : "R7", ro, ra, rb);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule